// File: doc/BRIEF.md
# Tagged Code Upload Port

This block sits between a host register bus and the instruction store of a small embedded controller. The host loads code one 32-bit word at a time through a per-port data window. Each access port keeps its own write pointer and control state. Before it streams words, the host writes a control word that holds a byte start offset, an auto-advance enable and a secure flag. The host can write a tag register at any point while a block is being filled.

The store is split into blocks of 64 words. A block becomes valid only when its last word (offset 63) has been written. At that moment the block takes the port's current tag and the secure flag of the control word that opened the upload. A write to word 0 of a block starts a new fill, so the block is invalid again until its last word lands.

A secure upload is refused when the secure capability input is zero. Writes that fall beyond the instruction store are dropped. Each of these two errors sets its own sticky flag. A read-back port shows any word and any block's metadata.

Top module: `code_upload_port`

## Requirements
- R1: After reset every block reads as not valid, and both error flags read 0.
- R2: Port p uses byte address 0x180+16p for its control word, 0x184+16p for its data window and 0x188+16p for its tag. The control word's bits [23:0] give a byte offset. A data write stores the 32-bit word at word index offset[23:2].
- R3: When control bit 24 is 1, each accepted data write advances the port's pointer by 4 bytes. Consecutive writes therefore land in consecutive words.
- R4: When control bit 24 is 0, repeated data writes overwrite the same word, and the following word is left unchanged.
- R5: A block is marked valid only when the word at offset 63 of that block is written. At that moment it latches the port's most recent tag write (bits [TAG_W-1:0]) and control bit 28 as its secure bit.
- R6: A write to the word at offset 0 of a block clears that block's valid bit.
- R7: A control write with bit 28 set while sec_cap is 0 is refused. err_secure goes to 1 and stays 1, and the port's data writes are dropped until its next control write. With a non-zero sec_cap, a secure upload proceeds and marks its block secure.
- R8: A data write whose word index is MEM_WORDS or above changes no memory word. It sets err_range, which stays 1 until reset.
- R9: Each port keeps an independent pointer. Interleaved writes on two ports land at each port's own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_cap | input | 2 | Secure capability; zero forbids secure uploads |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| rd_word | input | IDX_W | Word index for read-back |
| rd_data | output | 32 | Stored word at rd_word |
| rd_blk | input | BLK_IDX_W | Block index for read-back |
| rd_blk_valid | output | 1 | Valid bit of block rd_blk |
| rd_blk_tag | output | TAG_W | Tag of block rd_blk |
| rd_blk_secure | output | 1 | Secure bit of block rd_blk |
| err_secure | output | 1 | Sticky refused-secure-upload flag |
| err_range | output | 1 | Sticky out-of-range write flag |

## Verification
The bench fills a block with 63 words and checks that it is still invalid. It then changes the tag before the 64th word. A design that validates blocks early, or that latches the tag at the first word, reports the wrong valid bit or the old tag. A refused secure upload is checked against a word written earlier. A design that lets refused writes through overwrites that word. The store's last word is written, and then the write one past the end. A wrong bound either loses word 255 or leaves err_range clear. Interleaved traffic on two ports exposes a shared pointer as misplaced words.

// File: rtl/upl_pkg.sv
package upl_pkg;
  localparam int OFS_W    = 24;
  localparam int AINC_BIT = 24;
  localparam int SEC_BIT  = 28;
  localparam logic [11:0] WIN_BASE = 12'h180;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_TAG  = 2'd2,
    REG_RSVD = 2'd3
  } upl_reg_e;
endpackage

// File: rtl/upl_rst_sync.sv
module upl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/upl_decode.sv
module upl_decode
  import upl_pkg::*;
#(
  parameter int N_PORTS = 2
) (
  input  logic [11:0]        bus_addr,
  input  logic               bus_we,
  output logic [N_PORTS-1:0] ctrl_sel,
  output logic [N_PORTS-1:0] data_sel,
  output logic [N_PORTS-1:0] tag_sel
);
  logic [11:0] rel;
  logic        in_win;
  upl_reg_e    kind;

  always_comb begin
    rel    = bus_addr - WIN_BASE;
    in_win = bus_we && (bus_addr >= WIN_BASE) && (bus_addr[1:0] == 2'b00)
             && (int'(rel[11:4]) < N_PORTS);
    kind   = upl_reg_e'(rel[3:2]);
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_sel
    logic hit;
    assign hit         = in_win && (int'(rel[11:4]) == p);
    assign ctrl_sel[p] = hit && (kind == REG_CTRL);
    assign data_sel[p] = hit && (kind == REG_DATA);
    assign tag_sel[p]  = hit && (kind == REG_TAG);
  end
endmodule

// File: rtl/upl_port_ctx.sv
module upl_port_ctx
  import upl_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             data_we,
  input  logic             tag_we,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             ainc_in,
  input  logic             sec_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             cap_zero,
  output logic [OFS_W-1:0] ptr_o,
  output logic             sec_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             refused_o,
  output logic             refuse_evt_o
);
  logic [OFS_W-1:0] ptr_q, ptr_d;
  logic             ainc_q, ainc_d;
  logic             sec_q, sec_d;
  logic             ref_q, ref_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             refuse_evt;

  always_comb begin
    refuse_evt = ctrl_we && sec_in && cap_zero;
    ptr_d  = ptr_q;
    ainc_d = ainc_q;
    sec_d  = sec_q;
    ref_d  = ref_q;
    tag_d  = tag_q;
    if (ctrl_we) begin
      ptr_d  = ofs_in;
      ainc_d = ainc_in;
      sec_d  = sec_in;
      ref_d  = refuse_evt;
    end else if (data_we && !ref_q && ainc_q) begin
      ptr_d = ptr_q + OFS_W'(4);
    end
    if (tag_we) begin
      tag_d = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ainc_q <= 1'b0;
      sec_q  <= 1'b0;
      ref_q  <= 1'b0;
      tag_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      ainc_q <= ainc_d;
      sec_q  <= sec_d;
      ref_q  <= ref_d;
      tag_q  <= tag_d;
    end
  end

  assign ptr_o        = ptr_q;
  assign sec_o        = sec_q;
  assign tag_o        = tag_q;
  assign refused_o    = ref_q;
  assign refuse_evt_o = refuse_evt;
endmodule

// File: rtl/upl_store.sv
module upl_store #(
  parameter int MEM_WORDS = 256,
  parameter int BLK_WORDS = 64,
  parameter int TAG_W     = 16,
  parameter int IDX_W     = $clog2(MEM_WORDS),
  parameter int OFF_W     = $clog2(BLK_WORDS),
  parameter int N_BLK     = MEM_WORDS / BLK_WORDS,
  parameter int BLK_IDX_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [31:0]          wdata,
  input  logic [TAG_W-1:0]     wtag,
  input  logic                 wsec,
  input  logic [IDX_W-1:0]     ridx,
  output logic [31:0]          rdata,
  input  logic [BLK_IDX_W-1:0] rblk,
  output logic [N_BLK-1:0]     valid_vec,
  output logic [TAG_W-1:0]     rtag,
  output logic                 rsec
);
  logic [31:0]      mem_q   [MEM_WORDS];
  logic [TAG_W-1:0] btag_q  [N_BLK];
  logic [N_BLK-1:0] bsec_q;
  logic [N_BLK-1:0] valid_q, valid_d;
  logic [OFF_W-1:0] off;
  logic [BLK_IDX_W-1:0] blk;
  logic             last_w;

  always_comb begin
    off    = widx[OFF_W-1:0];
    blk    = BLK_IDX_W'(widx >> OFF_W);
    last_w = we && (int'(off) == BLK_WORDS - 1);
    valid_d = valid_q;
    if (we && (off == '0)) valid_d[blk] = 1'b0;
    if (last_w)            valid_d[blk] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar b = 0; b < N_BLK; b++) begin : g_meta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        btag_q[b] <= '0;
        bsec_q[b] <= 1'b0;
      end else if (last_w && (int'(blk) == b)) begin
        btag_q[b] <= wtag;
        bsec_q[b] <= wsec;
      end
    end
  end

  assign rdata     = mem_q[ridx];
  assign valid_vec = valid_q;
  assign rtag      = btag_q[rblk];
  assign rsec      = bsec_q[rblk];
endmodule

// File: rtl/code_upload_port.sv
module code_upload_port
  import upl_pkg::*;
#(
  parameter int N_PORTS   = 2,
  parameter int MEM_WORDS = 256,
  parameter int BLK_WORDS = 64,
  parameter int TAG_W     = 16,
  parameter int IDX_W     = $clog2(MEM_WORDS),
  parameter int BLK_IDX_W = ((MEM_WORDS / BLK_WORDS) > 1) ? $clog2(MEM_WORDS / BLK_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sec_cap,
  input  logic [11:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  input  logic [IDX_W-1:0]     rd_word,
  output logic [31:0]          rd_data,
  input  logic [BLK_IDX_W-1:0] rd_blk,
  output logic                 rd_blk_valid,
  output logic [TAG_W-1:0]     rd_blk_tag,
  output logic                 rd_blk_secure,
  output logic                 err_secure,
  output logic                 err_range
);
  localparam int N_BLK = MEM_WORDS / BLK_WORDS;

  logic rst_sync_n;
  logic [N_PORTS-1:0] ctrl_sel, data_sel, tag_sel;
  logic [OFS_W-1:0]   ptr_a   [N_PORTS];
  logic [TAG_W-1:0]   tag_a   [N_PORTS];
  logic [N_PORTS-1:0] sec_a, ref_a, refuse_a;
  logic [OFS_W-1:0]   sel_ptr;
  logic [TAG_W-1:0]   sel_tag;
  logic               sel_sec, sel_ref, data_hit;
  logic               in_range, mem_we, range_evt;
  logic [IDX_W-1:0]   mem_idx;
  logic [N_BLK-1:0]   blk_valid;
  logic               err_sec_q, err_sec_d, err_rng_q, err_rng_d;

  upl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  upl_decode #(.N_PORTS(N_PORTS)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ctrl_sel (ctrl_sel),
    .data_sel (data_sel),
    .tag_sel  (tag_sel)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    upl_port_ctx #(.TAG_W(TAG_W)) u_ctx (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .ctrl_we      (ctrl_sel[p]),
      .data_we      (data_sel[p]),
      .tag_we       (tag_sel[p]),
      .ofs_in       (bus_wdata[OFS_W-1:0]),
      .ainc_in      (bus_wdata[AINC_BIT]),
      .sec_in       (bus_wdata[SEC_BIT]),
      .tag_in       (bus_wdata[TAG_W-1:0]),
      .cap_zero     (sec_cap == 2'b00),
      .ptr_o        (ptr_a[p]),
      .sec_o        (sec_a[p]),
      .tag_o        (tag_a[p]),
      .refused_o    (ref_a[p]),
      .refuse_evt_o (refuse_a[p])
    );
  end

  always_comb begin
    sel_ptr = '0;
    sel_tag = '0;
    sel_sec = 1'b0;
    sel_ref = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (data_sel[p]) begin
        sel_ptr = ptr_a[p];
        sel_tag = tag_a[p];
        sel_sec = sec_a[p];
        sel_ref = ref_a[p];
      end
    end
    data_hit  = |data_sel;
    in_range  = (sel_ptr[OFS_W-1:2] < (OFS_W-2)'(MEM_WORDS));
    mem_we    = data_hit && !sel_ref && in_range;
    range_evt = data_hit && !sel_ref && !in_range;
    mem_idx   = sel_ptr[IDX_W+1:2];
    err_sec_d = err_sec_q | (|refuse_a);
    err_rng_d = err_rng_q | range_evt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_sec_q <= 1'b0;
      err_rng_q <= 1'b0;
    end else begin
      err_sec_q <= err_sec_d;
      err_rng_q <= err_rng_d;
    end
  end

  upl_store #(
    .MEM_WORDS (MEM_WORDS),
    .BLK_WORDS (BLK_WORDS),
    .TAG_W     (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (mem_we),
    .widx      (mem_idx),
    .wdata     (bus_wdata),
    .wtag      (sel_tag),
    .wsec      (sel_sec),
    .ridx      (rd_word),
    .rdata     (rd_data),
    .rblk      (rd_blk),
    .valid_vec (blk_valid),
    .rtag      (rd_blk_tag),
    .rsec      (rd_blk_secure)
  );

  assign rd_blk_valid = blk_valid[rd_blk];
  assign err_secure   = err_sec_q;
  assign err_range    = err_rng_q;
endmodule

// File: rtl/code_upload_chk.sv
module code_upload_chk #(
  parameter int MEM_WORDS = 256,
  parameter int BLK_WORDS = 64,
  parameter int IDX_W     = $clog2(MEM_WORDS),
  parameter int OFF_W     = $clog2(BLK_WORDS),
  parameter int N_BLK     = MEM_WORDS / BLK_WORDS
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bus_we,
  input logic [1:0]       sec_cap,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_idx,
  input logic [N_BLK-1:0] blk_valid,
  input logic             err_secure,
  input logic             err_range
);
  AST_WRITE_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> bus_we); // R2

  AST_BLOCK_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && (int'(mem_idx[OFF_W-1:0]) == BLK_WORDS - 1))
    |=> blk_valid[$past(mem_idx >> OFF_W)]); // R5

  AST_BLOCK_OPEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && (mem_idx[OFF_W-1:0] == '0))
    |=> !blk_valid[$past(mem_idx >> OFF_W)]); // R6

  AST_SECURE_REFUSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_secure) |-> ($past(sec_cap) == 2'b00)); // R7

  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$fell(err_secure)); // R7

  AST_RANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_range) |-> $past(bus_we)); // R8

  AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$fell(err_range)); // R8
endmodule

bind code_upload_port code_upload_chk #(
  .MEM_WORDS (MEM_WORDS),
  .BLK_WORDS (BLK_WORDS)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_we     (bus_we),
  .sec_cap    (sec_cap),
  .mem_we     (mem_we),
  .mem_idx    (mem_idx),
  .blk_valid  (blk_valid),
  .err_secure (err_secure),
  .err_range  (err_range)
);

// File: tb/sim_code_upload_port.sv
module sim_code_upload_port;
  localparam int TAG_W = 16;

  logic        clk;
  logic        rst_n;
  logic [1:0]  sec_cap;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [7:0]  rd_word;
  logic [31:0] rd_data;
  logic [1:0]  rd_blk;
  logic        rd_blk_valid;
  logic [TAG_W-1:0] rd_blk_tag;
  logic        rd_blk_secure;
  logic        err_secure;
  logic        err_range;

  int checks = 0;
  int errors = 0;

  code_upload_port u0 (
    .clk (clk), .rst_n (rst_n), .sec_cap (sec_cap),
    .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
    .rd_word (rd_word), .rd_data (rd_data), .rd_blk (rd_blk),
    .rd_blk_valid (rd_blk_valid), .rd_blk_tag (rd_blk_tag),
    .rd_blk_secure (rd_blk_secure), .err_secure (err_secure),
    .err_range (err_range)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input logic [23:0] ofs, input logic ainc, input logic sec);
    return {3'b000, sec, 3'b000, ainc, ofs};
  endfunction

  function automatic logic [11:0] pa(input int p, input int r);
    return 12'(12'h180 + 16 * p + 4 * r);
  endfunction

  task automatic rdw(input int idx, output logic [31:0] v);
    rd_word = 8'(idx); #1; v = rd_data;
  endtask

  task automatic rdb(input int b);
    rd_blk = 2'(b); #1;
  endtask

  task automatic t_reset();
    for (int b = 0; b < 4; b++) begin
      rdb(b);
      chk("R1 block valid after reset", {31'd0, rd_blk_valid}, 32'd0);
    end
    chk("R1 err_secure after reset", {31'd0, err_secure}, 32'd0);
    chk("R1 err_range after reset", {31'd0, err_range}, 32'd0);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    wr(pa(0, 0), ctl(24'h100, 1'b1, 1'b0));
    wr(pa(0, 2), 32'h5A);
    for (int i = 0; i < 63; i++) wr(pa(0, 1), 32'h1000 + i);
    rdb(1);
    chk("R5 block not valid after 63 words", {31'd0, rd_blk_valid}, 32'd0);
    wr(pa(0, 2), 32'h77);
    wr(pa(0, 1), 32'h1000 + 63);
    rdb(1);
    chk("R5 block valid after 64th word", {31'd0, rd_blk_valid}, 32'd1);
    chk("R5 tag latched at completion", 32'(rd_blk_tag), 32'h77);
    chk("R5 secure bit clear", {31'd0, rd_blk_secure}, 32'd0);
    rdw(64, v);  chk("R2 first word at start offset", v, 32'h1000);
    rdw(100, v); chk("R3 auto-increment word 36", v, 32'h1000 + 36);
    rdw(127, v); chk("R3 auto-increment last word", v, 32'h1000 + 63);
  endtask

  task automatic t_noinc();
    logic [31:0] v;
    wr(pa(0, 0), ctl(24'h14, 1'b0, 1'b0));
    wr(pa(0, 1), 32'h55);
    wr(pa(0, 0), ctl(24'h10, 1'b0, 1'b0));
    wr(pa(0, 1), 32'hA);
    wr(pa(0, 1), 32'hB);
    rdw(4, v); chk("R4 same word overwritten", v, 32'hB);
    rdw(5, v); chk("R4 next word untouched", v, 32'h55);
  endtask

  task automatic t_reopen();
    wr(pa(0, 0), ctl(24'h100, 1'b1, 1'b0));
    wr(pa(0, 1), 32'hCAFE);
    rdb(1);
    chk("R6 block invalid after offset-0 write", {31'd0, rd_blk_valid}, 32'd0);
  endtask

  task automatic t_secure();
    logic [31:0] v;
    wr(pa(0, 0), ctl(24'h0, 1'b0, 1'b0));
    wr(pa(0, 1), 32'h11);
    sec_cap = 2'b00;
    wr(pa(1, 0), ctl(24'h0, 1'b1, 1'b1));
    wr(pa(1, 1), 32'hDEAD);
    chk("R7 err_secure set on refused upload", {31'd0, err_secure}, 32'd1);
    rdw(0, v); chk("R7 refused write dropped", v, 32'h11);
    sec_cap = 2'b01;
    wr(pa(1, 0), ctl(24'h0, 1'b1, 1'b1));
    wr(pa(1, 2), 32'h33);
    for (int i = 0; i < 64; i++) wr(pa(1, 1), 32'h2200 + i);
    rdb(0);
    chk("R7 secure upload block valid", {31'd0, rd_blk_valid}, 32'd1);
    chk("R7 secure bit latched", {31'd0, rd_blk_secure}, 32'd1);
    chk("R5 tag of secure block", 32'(rd_blk_tag), 32'h33);
    rdw(0, v); chk("R7 secure word stored", v, 32'h2200);
    chk("R7 err_secure sticky", {31'd0, err_secure}, 32'd1);
  endtask

  task automatic t_range();
    logic [31:0] v;
    wr(pa(0, 0), ctl(24'h3FC, 1'b1, 1'b0));
    wr(pa(0, 1), 32'h99);
    chk("R8 no error at last word", {31'd0, err_range}, 32'd0);
    wr(pa(0, 1), 32'h98);
    rdw(255, v); chk("R8 last word kept", v, 32'h99);
    chk("R8 err_range set past end", {31'd0, err_range}, 32'd1);
    wr(pa(0, 0), ctl(24'h200, 1'b1, 1'b0));
    wr(pa(0, 1), 32'h7);
    chk("R8 err_range sticky", {31'd0, err_range}, 32'd1);
  endtask

  task automatic t_ports();
    logic [31:0] v;
    wr(pa(0, 0), ctl(24'h200, 1'b1, 1'b0));
    wr(pa(1, 0), ctl(24'h280, 1'b1, 1'b0));
    wr(pa(0, 1), 32'hA1);
    wr(pa(1, 1), 32'hB1);
    wr(pa(0, 1), 32'hA2);
    rdw(128, v); chk("R9 port0 first word", v, 32'hA1);
    rdw(129, v); chk("R9 port0 second word", v, 32'hA2);
    rdw(160, v); chk("R9 port1 own pointer", v, 32'hB1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_cap = 2'b01; bus_addr = '0; bus_we = 1'b0;
    bus_wdata = '0; rd_word = '0; rd_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_noinc();
    t_reopen();
    t_secure();
    t_ports();
    t_range();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule